// File: doc/BRIEF.md
# Preloadable 8-bit Event Counter with Frequency Output

This block is an 8-bit up-counter for a small microcontroller. Software sees it through two register locations. A write to the data location stores a reload value in a separate preload register. A read of the same location returns the count as it stands in that cycle. The control location selects what advances the count: ticks of the internal time base (a clock enable from the prescaler), edges of an external event input, or internal ticks gated by the level of that external input. The last of these is used to measure pulse widths.

When the counter steps past its all-ones value, it reloads from the preload register and raises a one-cycle interrupt request. In the same cycle it toggles a square-wave output. Each half period of that wave therefore lasts 256 − N counted ticks, where N is the preload value. The output frequency is the tick rate divided by 2·(256 − N). When the timer is stopped, a preload write also copies the value into the live count, so the first period after enabling has the intended length.

Top module: `evtimer8`

## Requirements
- R1: After reset, the control location reads 0x08, the data location reads 0x00, and both irq and pfd_out are 0.
- R2: When the timer is stopped (enable bit 0 or mode 00), a write to the data location (bus_addr 0) sets both the preload value and the live count. A read of bus_addr 0 returns the live count.
- R3: When the timer is running, a write to the data location changes only the preload value. The live count does not change on the write, and the new value takes effect at the next overflow.
- R4: The control location (bus_addr 1) has this layout: bits 7:6 mode, bit 4 enable, bit 3 edge/level select. Bits 5 and 2:0 are not implemented and read 0, so writing 0xFF reads back 0xD8.
- R5: In mode 10 with enable set, the count rises by exactly one for each cycle in which tick_en is high, and holds in every other cycle.
- R6: A count step taken at 0xFF loads the preload value, and irq is high for exactly the one cycle that follows that step.
- R7: pfd_out toggles on every overflow. With tick_en held high and preload N, each half period of pfd_out lasts 256 − N cycles.
- R8: In mode 01 with enable set, each edge of evt_in advances the count once, after synchronisation. Select bit 0 counts rising edges and select bit 1 counts falling edges. Edges of the other polarity and tick_en are both ignored.
- R9: In mode 11 with enable set, the count advances on tick_en only while the synchronised evt_in is at the selected level (select bit 0 means high, select bit 1 means low).
- R10: With mode 00, or with the enable bit clear, neither tick_en nor evt_in changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_addr | input | 1 | 0 selects the data location, 1 selects the control location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the location on bus_addr, combinational |
| tick_en | input | 1 | Internal time-base clock enable from the prescaler |
| evt_in | input | 1 | External event or gate input, asynchronous |
| irq | output | 1 | One-cycle overflow interrupt request |
| pfd_out | output | 1 | Square wave that toggles on each overflow |

## Verification
The assertions assume that bus_wr is a clean single-cycle strobe and that tick_en is a synchronous enable. They also assume that evt_in reaches the counter only through the two-stage synchroniser, so one input edge gives at most one count pulse. The stimulus drives every input at the falling clock edge. It holds evt_in steady for several cycles around each edge, longer than the synchroniser depth, so every event is seen exactly once. The stimulus reconfigures the control register only while the mode logic would produce no count step.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_GATED = 2'b11
  } tmode_e;

  // Control field positions (R4)
  localparam int MODE_HI = 7;
  localparam int MODE_LO = 6;
  localparam int EN_BIT  = 4;
  localparam int SEL_BIT = 3;

  // Count advance for one step: next value and overflow flag
  function automatic logic [8:0] step_count(input logic [7:0] cur, input logic [7:0] pre);
    if (cur == 8'hFF) return {1'b1, pre};
    return {1'b0, cur + 8'd1};
  endfunction

  // Cycles between pfd toggles when every cycle is a tick
  function automatic int half_period(input logic [7:0] pre);
    return 256 - int'(pre);
  endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic level,
  output logic edge_pulse
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;

  logic rise_w, fall_w;
  assign rise_w     = level & ~prev;
  assign fall_w     = ~level & prev;
  assign edge_pulse = fall_sel ? fall_w : rise_w;

  // R8
  rise_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> !rise_w);
  // R8
  fall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> !fall_w);

endmodule

// File: rtl/evt_ctrl_reg.sv
module evt_ctrl_reg
  import evtimer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output tmode_e        mode,
  output logic          enable,
  output logic          sel
);
  localparam logic [DW-1:0] IMPL_MASK = DW'(8'hD8);
  localparam logic [DW-1:0] RST_VAL   = DW'(8'h08);

  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  ctrl_q <= RST_VAL;
    else if (wr) ctrl_q <= wdata & IMPL_MASK;

  assign rd_val = ctrl_q;
  assign mode   = tmode_e'(ctrl_q[MODE_HI:MODE_LO]);
  assign enable = ctrl_q[EN_BIT];
  assign sel    = ctrl_q[SEL_BIT];

  // R4
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rd_val == ($past(wdata) & IMPL_MASK));

endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evtimer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       step,
  input  logic       load_wr,
  input  logic [7:0] load_val,
  output logic [7:0] cnt,
  output logic       ovf_evt,
  output logic       irq,
  output logic       pfd
);
  logic [7:0] pre_q;
  logic [8:0] nxt;

  assign nxt     = step_count(cnt, pre_q);
  assign ovf_evt = step & nxt[8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pre_q <= '0;
    else if (load_wr) pre_q <= load_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (step)             cnt <= nxt[7:0];
    else if (load_wr && !run)  cnt <= load_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq <= 1'b0;
      pfd <= 1'b0;
    end else begin
      irq <= ovf_evt;
      pfd <= pfd ^ ovf_evt;
    end

  // R5
  count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != 8'hFF) |=> cnt == $past(cnt) + 8'd1);
  // R6
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == 8'hFF) |=> cnt == $past(pre_q) && irq);
  // R3
  run_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_wr && !step) |=> $stable(cnt));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_wr) |=> $stable(cnt));
  // R7
  pfd_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$stable(pfd));
  // R7
  pfd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(pfd));

endmodule

// File: rtl/evtimer8.sv
module evtimer8
  import evtimer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick_en,
  input  logic       evt_in,
  output logic       irq,
  output logic       pfd_out
);
  logic [7:0] ctrl_rd, cnt;
  tmode_e     mode;
  logic       enable, sel, level, edge_pulse, ovf_evt;
  logic       run, step, level_ok, data_wr, ctrl_wr;

  assign data_wr = bus_wr & ~bus_addr;
  assign ctrl_wr = bus_wr &  bus_addr;

  evt_ctrl_reg #(.DW(8)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(bus_wdata),
    .rd_val(ctrl_rd), .mode(mode), .enable(enable), .sel(sel)
  );

  evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(evt_in), .fall_sel(sel),
    .level(level), .edge_pulse(edge_pulse)
  );

  assign run      = enable & (mode != MODE_OFF);
  assign level_ok = sel ? ~level : level;

  always_comb begin
    step = 1'b0;
    if (run) begin
      case (mode)
        MODE_EVENT: step = edge_pulse;
        MODE_TIMER: step = tick_en;
        MODE_GATED: step = tick_en & level_ok;
        default:    step = 1'b0;
      endcase
    end
  end

  evt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step),
    .load_wr(data_wr), .load_val(bus_wdata), .cnt(cnt),
    .ovf_evt(ovf_evt), .irq(irq), .pfd(pfd_out)
  );

  assign bus_rdata = bus_addr ? ctrl_rd : cnt;

  // R10
  stopped_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !step);
  // R6
  irq_follows_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> irq);

endmodule

// File: tb/evtimer8_test.sv
module evtimer8_test;
  logic       clk = 0, rst_n = 0;
  logic       bus_wr = 0, bus_addr = 0, tick_en = 0, evt_in = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       irq, pfd_out;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  evtimer8 uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .evt_in(evt_in), .irq(irq), .pfd_out(pfd_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata; bus_addr = 0;
  endtask

  task automatic tick_once();
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
  endtask

  task automatic evt_pulse();
    @(negedge clk); evt_in = 1; repeat (5) @(negedge clk);
    evt_in = 0; repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    rd(1'b1, v); check("R1 ctrl", v, 8'h08);
    rd(1'b0, v); check("R1 count", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 pfd", pfd_out, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(1'b1, 8'hFF); rd(1'b1, v); check("R4 all ones", v, 8'hD8);
    wr(1'b1, 8'h27); rd(1'b1, v); check("R4 unimpl bits", v, 8'h00);
    wr(1'b1, 8'h08);
  endtask

  task automatic t_stopped();
    logic [7:0] v;
    wr(1'b0, 8'h37); rd(1'b0, v); check("R2 stopped load", v, 8'h37);
    repeat (3) tick_once();
    evt_pulse();
    rd(1'b0, v); check("R10 disabled hold", v, 8'h37);
    wr(1'b1, 8'h18);
    repeat (3) tick_once();
    rd(1'b0, v); check("R10 mode00 hold", v, 8'h37);
    wr(1'b1, 8'h08);
  endtask

  task automatic t_timer();
    logic [7:0] v;
    wr(1'b0, 8'hF0);
    wr(1'b1, 8'h90);
    repeat (5) tick_once();
    rd(1'b0, v); check("R5 five ticks", v, 8'hF5);
    repeat (4) @(negedge clk);
    rd(1'b0, v); check("R5 no tick hold", v, 8'hF5);
    evt_pulse();
    rd(1'b0, v); check("R5 evt ignored", v, 8'hF5);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(1'b1, 8'h08);
    wr(1'b0, 8'hFC);
    wr(1'b1, 8'h90);
    repeat (3) tick_once();
    rd(1'b0, v); check("R6 at max", v, 8'hFF);
    check("R6 no irq yet", irq, 0);
    tick_once();
    rd(1'b0, v); check("R6 reload", v, 8'hFC);
    check("R6 irq high", irq, 1);
    check("R7 pfd toggled", pfd_out, 1);
    @(negedge clk);
    check("R6 irq one cycle", irq, 0);
  endtask

  task automatic t_run_write();
    logic [7:0] v;
    wr(1'b0, 8'h80);
    rd(1'b0, v); check("R3 count kept", v, 8'hFC);
    repeat (4) tick_once();
    rd(1'b0, v); check("R3 new preload used", v, 8'h80);
    check("R7 pfd back", pfd_out, 0);
  endtask

  task automatic t_pfd_period();
    int last = -1, cyc = 0, seen = 0;
    logic p;
    wr(1'b1, 8'h08);
    wr(1'b0, 8'hFA);
    @(negedge clk); tick_en = 1;
    wr(1'b1, 8'h90);
    p = pfd_out;
    for (int i = 0; i < 200 && seen < 4; i++) begin
      @(negedge clk); cyc++;
      if (pfd_out != p) begin
        if (last >= 0) check("R7 half period", cyc - last, 256 - 8'hFA);
        last = cyc; p = pfd_out; seen++;
      end
    end
    check("R7 toggles seen", seen, 4);
    tick_en = 0;
    wr(1'b1, 8'h08);
  endtask

  task automatic t_event();
    logic [7:0] v;
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h50);
    repeat (3) evt_pulse();
    rd(1'b0, v); check("R8 rising edges", v, 8'h13);
    repeat (3) tick_once();
    rd(1'b0, v); check("R8 tick ignored", v, 8'h13);
    wr(1'b1, 8'h58);
    repeat (2) evt_pulse();
    rd(1'b0, v); check("R8 falling edges", v, 8'h15);
    @(negedge clk); evt_in = 1; repeat (6) @(negedge clk);
    rd(1'b0, v); check("R8 rise ignored on fall sel", v, 8'h15);
    evt_in = 0; repeat (6) @(negedge clk);
    wr(1'b1, 8'h08);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hD0);
    repeat (3) tick_once();
    rd(1'b0, v); check("R9 gate closed", v, 8'h00);
    @(negedge clk); evt_in = 1; repeat (4) @(negedge clk);
    repeat (3) tick_once();
    rd(1'b0, v); check("R9 gate high", v, 8'h03);
    @(negedge clk); evt_in = 0; repeat (4) @(negedge clk);
    wr(1'b1, 8'hD8);
    repeat (2) tick_once();
    rd(1'b0, v); check("R9 gate low", v, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_stopped();
    t_timer();
    t_overflow();
    t_run_write();
    t_pfd_period();
    t_event();
    t_gate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule